// File: doc/BRIEF.md
# Scanline Table Transfer Engine

This block moves short data bursts from memory to a peripheral register bus once per video line. It works per channel from a table held in memory. The table holds a sequence of entries. Each entry starts with a line-control byte. In indirect mode that byte is followed by a two-byte data pointer. In direct mode the data bytes follow the line-control byte in the table itself.

At the start of a frame, each enabled channel is rewound to the start of its table and its first entry is loaded. On each later line strobe, every live channel that has a transfer armed sends a burst of 1, 2 or 4 bytes, to register offsets set by its transfer mode. It then counts the line down and loads the next entry when the count runs out.

Whenever the engine starts a job, it takes the enabled channels away from the general DMA sequencer. It also holds off that sequencer for as long as it is busy.

The state machine has these states:
- `ST_IDLE`: waits for a pending job.
- `ST_OVH`: the fixed overhead.
- `ST_SCAN`: picks the next channel.
- `ST_INIT_LD`: loads the first line-control byte at frame start.
- `ST_BURST`: moves the data bytes.
- `ST_DEC`: counts the line down.
- `ST_RL_CNT`: reloads the line-control byte.
- `ST_RL_IL` and `ST_RL_IH`: read the low and high bytes of the indirect pointer.

The transitions are:
- IDLE→OVH when a job is pending and the mask is non-zero.
- OVH→SCAN after the overhead count.
- SCAN→INIT_LD, BURST or DEC when a channel is found, and SCAN→IDLE when none is left.
- INIT_LD or RL_CNT→RL_IL in indirect mode with a non-zero byte, otherwise →SCAN.
- BURST→DEC on the last byte.
- DEC→RL_CNT when the count reaches zero, otherwise →SCAN.
- RL_IL→RL_IH→SCAN.

Top module: `hdma_engine`

## Requirements
- R1: After reset, `busy`, `bus_we`, `mem_rd` and `gdma_stop` are all low.
- R2: `frame_start` clears the finished flag of every channel, enabled or not. A table that has run to its end replays from its first entry after the next frame initialisation.
- R3: With `chan_en` all zero, frame and line strobes are discarded: `busy` stays low and nothing is read or written.
- R4: Frame initialisation sets each enabled channel's table pointer to its `cfg_src` and reads the line-control byte there, and moves no data. In indirect mode it then reads a two-byte data pointer, low byte first, and the transfer flag is armed.
- R5: A line-control byte of 0x00 marks the channel finished for the rest of the frame. A finished channel moves no data on later lines.
- R6: The burst length by mode 0..7 is 1,2,2,4,4,4,2,4. The register offsets added to `cfg_dest` are as follows:
  - mode 0: 0
  - modes 1 and 5: 0,1 repeating
  - modes 2 and 6: 0 for every byte
  - modes 3 and 7: 0,0,1,1
  - mode 4: 0,1,2,3
- R7: In direct mode (`cfg_indir`=0), data bytes come from the table pointer, which advances by one per byte.
- R8: In indirect mode, data bytes come from the data pointer, which advances by one per byte while the table pointer stays put.
- R9: Bit 7 of the line-control byte selects repeat and bits 6:0 give a line count. Without repeat, data moves on the first line of the entry only. With repeat, data moves on every line. The next entry is loaded after the line that takes the count to zero.
- R10: Every job spends 8 cycles of overhead before its first memory access. A job that finds no channel to serve holds `busy` high for exactly 9 cycles.
- R11: A pending line job is served before a pending frame initialisation. `gdma_grant` is high only while `gdma_req` is high, the engine is idle and no job is pending.
- R12: At the start of each job, `gdma_stop` carries `chan_en` for exactly one cycle.
- R13: Within a job, channels are served in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame-start strobe, one cycle |
| line_strobe | input | 1 | Line-boundary strobe, one cycle |
| chan_en | input | NCH | Channel enable mask |
| cfg_src | input | NCH*AW | Per-channel table start address |
| cfg_mode | input | NCH*3 | Per-channel transfer mode |
| cfg_indir | input | NCH | Per-channel indirect-mode select |
| cfg_dest | input | NCH*8 | Per-channel register bus base address |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |
| bus_we | output | 1 | Register bus write strobe |
| bus_addr | output | 8 | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| gdma_req | input | 1 | General DMA sequencer wants the memory |
| gdma_grant | output | 1 | General DMA may run |
| gdma_stop | output | NCH | Channels taken from the general DMA sequencer |
| busy | output | 1 | Engine is running a job |

## Verification
A frame-start strobe and a line strobe can arrive in the same cycle. The frame strobe clears the finished flags at once, and both jobs then queue behind each other. The bench raises both strobes together with the general DMA request held high. It expects two separate stop pulses and no cycle in which the grant and `busy` are high together. It then judges the order from the next line on its own: only if the line job ran first and the initialisation second does that line produce the first-entry bursts of every table.

// File: rtl/hdma_pkg.sv
package hdma_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OVH,
        ST_SCAN,
        ST_INIT_LD,
        ST_BURST,
        ST_DEC,
        ST_RL_CNT,
        ST_RL_IL,
        ST_RL_IH
    } hdma_state_t;

    // number of bytes moved per line for a transfer mode
    function automatic logic [2:0] burst_len(input logic [2:0] mode);
        logic [2:0] n;
        unique case (mode)
            3'd0:                 n = 3'd1;
            3'd1, 3'd2, 3'd6:     n = 3'd2;
            default:              n = 3'd4;
        endcase
        return n;
    endfunction

    // register offset for byte number idx of a burst
    function automatic logic [1:0] burst_off(input logic [2:0] mode, input logic [1:0] idx);
        logic [1:0] o;
        unique case (mode)
            3'd1, 3'd5: o = {1'b0, idx[0]};
            3'd3, 3'd7: o = {1'b0, idx[1]};
            3'd4:       o = idx;
            default:    o = 2'd0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/hdma_chan_file.sv
module hdma_chan_file #(
    parameter int NCH = 8,
    parameter int AW  = 16,
    localparam int IW = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_fin_all,
    input  logic [IW-1:0] wsel,
    input  logic          we_tbl,
    input  logic [AW-1:0] tbl_d,
    input  logic          we_ind,
    input  logic [AW-1:0] ind_d,
    input  logic          we_cnt,
    input  logic [7:0]    cnt_d,
    input  logic          we_do,
    input  logic          do_d,
    input  logic          we_fin,
    input  logic          fin_d,
    output logic [AW-1:0] tbl_q [NCH],
    output logic [AW-1:0] ind_q [NCH],
    output logic [7:0]    cnt_q [NCH],
    output logic [NCH-1:0] do_q,
    output logic [NCH-1:0] fin_q
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = (wsel == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tbl_q[g] <= '0;
                ind_q[g] <= '0;
                cnt_q[g] <= '0;
                do_q[g]  <= 1'b0;
                fin_q[g] <= 1'b0;
            end else begin
                if (hit && we_tbl) tbl_q[g] <= tbl_d;
                if (hit && we_ind) ind_q[g] <= ind_d;
                if (hit && we_cnt) cnt_q[g] <= cnt_d;
                if (hit && we_do)  do_q[g]  <= do_d;
                if (clr_fin_all)
                    fin_q[g] <= 1'b0;
                else if (hit && we_fin)
                    fin_q[g] <= fin_d;
            end
        end
    end

endmodule

// File: rtl/hdma_pick.sv
module hdma_pick #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] cand,
    input  logic [IW:0]    from,
    output logic           found,
    output logic [IW-1:0]  idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/hdma_engine.sv
module hdma_engine
    import hdma_pkg::*;
#(
    parameter int NCH     = 8,
    parameter int AW      = 16,
    parameter int OVH_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_strobe,
    input  logic [NCH-1:0]    chan_en,
    input  logic [NCH*AW-1:0] cfg_src,
    input  logic [NCH*3-1:0]  cfg_mode,
    input  logic [NCH-1:0]    cfg_indir,
    input  logic [NCH*8-1:0]  cfg_dest,
    output logic              mem_rd,
    output logic [AW-1:0]     mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              bus_we,
    output logic [7:0]        bus_addr,
    output logic [7:0]        bus_wdata,
    input  logic              gdma_req,
    output logic              gdma_grant,
    output logic [NCH-1:0]    gdma_stop,
    output logic              busy
);

    localparam int IW = $clog2(NCH);
    localparam int OW = $clog2(OVH_CYC + 1);

    hdma_state_t state, nxt;
    logic [OW-1:0] ovh_cnt;
    logic [IW-1:0] cur;
    logic [IW:0]   scan_from;
    logic [1:0]    bidx;
    logic          in_init;
    logic          line_pend, init_pend;

    // channel file write side
    logic          we_tbl, we_ind, we_cnt, we_do, we_fin;
    logic [AW-1:0] tbl_d, ind_d;
    logic [7:0]    cnt_d;
    logic          do_d, fin_d;
    logic [AW-1:0] tbl_q [NCH];
    logic [AW-1:0] ind_q [NCH];
    logic [7:0]    cnt_q [NCH];
    logic [NCH-1:0] do_q, fin_q;

    // selected channel view
    logic [AW-1:0] cur_src, cur_tbl, cur_ind;
    logic [2:0]    cur_mode;
    logic [7:0]    cur_dest, cur_cnt, cnt_dec;
    logic          cur_indir, last_byte;

    logic          any_en, any_pend, start_job, take_line, take_init;
    logic [NCH-1:0] cand;
    logic          pick_found;
    logic [IW-1:0] pick_idx;

    hdma_chan_file #(.NCH(NCH), .AW(AW)) u_file (
        .clk(clk), .rst_n(rst_n), .clr_fin_all(frame_start), .wsel(cur),
        .we_tbl(we_tbl), .tbl_d(tbl_d), .we_ind(we_ind), .ind_d(ind_d),
        .we_cnt(we_cnt), .cnt_d(cnt_d), .we_do(we_do), .do_d(do_d),
        .we_fin(we_fin), .fin_d(fin_d),
        .tbl_q(tbl_q), .ind_q(ind_q), .cnt_q(cnt_q), .do_q(do_q), .fin_q(fin_q)
    );

    assign cand = in_init ? chan_en : (chan_en & ~fin_q);

    hdma_pick #(.NCH(NCH)) u_pick (
        .cand(cand), .from(scan_from), .found(pick_found), .idx(pick_idx)
    );

    always_comb begin
        cur_src   = cfg_src[int'(cur)*AW +: AW];
        cur_mode  = cfg_mode[int'(cur)*3 +: 3];
        cur_dest  = cfg_dest[int'(cur)*8 +: 8];
        cur_indir = cfg_indir[cur];
        cur_tbl   = tbl_q[cur];
        cur_ind   = ind_q[cur];
        cur_cnt   = cnt_q[cur];
        cnt_dec   = cur_cnt - 8'd1;
        last_byte = ({1'b0, bidx} == (burst_len(cur_mode) - 3'd1));
    end

    assign any_en    = |chan_en;
    assign any_pend  = line_pend | init_pend;
    assign start_job = (state == ST_IDLE) && any_pend && any_en;
    // line first; an empty mask discards everything pending
    assign take_line = (state == ST_IDLE) && line_pend;
    assign take_init = (state == ST_IDLE) && init_pend && (!line_pend || !any_en);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_job) nxt = ST_OVH;
            ST_OVH:     if (ovh_cnt == OW'(OVH_CYC - 1)) nxt = ST_SCAN;
            ST_SCAN: begin
                if (!pick_found)     nxt = ST_IDLE;
                else if (in_init)    nxt = ST_INIT_LD;
                else if (do_q[pick_idx]) nxt = ST_BURST;
                else                 nxt = ST_DEC;
            end
            ST_INIT_LD,
            ST_RL_CNT:  nxt = (mem_rdata != 8'h00 && cur_indir) ? ST_RL_IL : ST_SCAN;
            ST_BURST:   if (last_byte) nxt = ST_DEC;
            ST_DEC:     nxt = (cnt_dec[6:0] == 7'd0) ? ST_RL_CNT : ST_SCAN;
            ST_RL_IL:   nxt = ST_RL_IH;
            ST_RL_IH:   nxt = ST_SCAN;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register and sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ovh_cnt   <= '0;
            cur       <= '0;
            scan_from <= '0;
            bidx      <= '0;
            in_init   <= 1'b0;
            line_pend <= 1'b0;
            init_pend <= 1'b0;
        end else begin
            state     <= nxt;
            line_pend <= line_strobe | (line_pend & ~take_line);
            init_pend <= frame_start | (init_pend & ~take_init);
            unique case (state)
                ST_IDLE: begin
                    ovh_cnt   <= '0;
                    scan_from <= '0;
                    if (start_job) in_init <= !line_pend;
                end
                ST_OVH:   ovh_cnt <= ovh_cnt + OW'(1);
                ST_SCAN: begin
                    if (pick_found) begin
                        cur       <= pick_idx;
                        scan_from <= {1'b0, pick_idx} + (IW+1)'(1);
                    end
                    bidx <= '0;
                end
                ST_BURST: bidx <= bidx + 2'd1;
                default: ;
            endcase
        end
    end

    // outputs and channel-file updates
    always_comb begin
        mem_rd    = 1'b0;
        mem_addr  = cur_tbl;
        bus_we    = 1'b0;
        bus_addr  = cur_dest + {6'd0, burst_off(cur_mode, bidx)};
        bus_wdata = mem_rdata;
        we_tbl = 1'b0; tbl_d = cur_tbl + AW'(1);
        we_ind = 1'b0; ind_d = cur_ind + AW'(1);
        we_cnt = 1'b0; cnt_d = mem_rdata;
        we_do  = 1'b0; do_d  = 1'b1;
        we_fin = 1'b0; fin_d = (mem_rdata == 8'h00);
        unique case (state)
            ST_INIT_LD: begin
                mem_rd   = 1'b1;
                mem_addr = cur_src;
                we_tbl   = 1'b1;
                tbl_d    = cur_src + AW'(1);
                we_cnt   = 1'b1;
                we_do    = 1'b1;
                we_fin   = 1'b1;
            end
            ST_BURST: begin
                mem_rd   = 1'b1;
                mem_addr = cur_indir ? cur_ind : cur_tbl;
                bus_we   = 1'b1;
                we_ind   = cur_indir;
                we_tbl   = !cur_indir;
            end
            ST_DEC: begin
                we_cnt = 1'b1;
                cnt_d  = cnt_dec;
                we_do  = 1'b1;
                do_d   = cur_cnt[7];
            end
            ST_RL_CNT: begin
                mem_rd = 1'b1;
                we_tbl = 1'b1;
                we_cnt = 1'b1;
                we_do  = 1'b1;
                we_fin = 1'b1;
            end
            ST_RL_IL: begin
                mem_rd = 1'b1;
                we_tbl = 1'b1;
                we_ind = 1'b1;
                ind_d  = {cur_ind[AW-1:8], mem_rdata};
            end
            ST_RL_IH: begin
                mem_rd = 1'b1;
                we_tbl = 1'b1;
                we_ind = 1'b1;
                ind_d  = cur_ind;
                ind_d[15:8] = mem_rdata;
            end
            default: ;
        endcase
    end

    assign busy       = (state != ST_IDLE);
    assign gdma_stop  = start_job ? chan_en : '0;
    assign gdma_grant = gdma_req && (state == ST_IDLE) && !any_pend;

endmodule

// File: rtl/hdma_engine_chk.sv
module hdma_engine_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           mem_rd,
    input logic           bus_we,
    input logic           gdma_grant,
    input logic [NCH-1:0] gdma_stop,
    input logic [NCH-1:0] chan_en
);

    logic [4:0] busy_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              busy_age <= '0;
        else if (!busy)          busy_age <= '0;
        else if (busy_age != 5'd31) busy_age <= busy_age + 5'd1;
    end

    AST_STOP_STARTS_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        (|gdma_stop) |-> (!busy ##1 busy));                                   // R12

    AST_GRANT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        gdma_grant |-> (!busy && gdma_stop == '0));                           // R11

    AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (busy && mem_rd));                                         // R7

    AST_OVERHEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (busy_age >= 5'd8));                                       // R10

    AST_BUSY_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(|chan_en));                                     // R3

endmodule

bind hdma_engine hdma_engine_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .bus_we(bus_we),
    .gdma_grant(gdma_grant), .gdma_stop(gdma_stop), .chan_en(chan_en)
);

// File: tb/tb_hdma_engine.sv
module tb_hdma_engine;
    localparam int NCH = 8;
    localparam int AW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, line_strobe = 1'b0, gdma_req = 1'b0;
    logic [NCH-1:0]    chan_en = '0, cfg_indir = '0;
    logic [NCH*AW-1:0] cfg_src = '0;
    logic [NCH*3-1:0]  cfg_mode = '0;
    logic [NCH*8-1:0]  cfg_dest = '0;
    logic mem_rd, bus_we, gdma_grant, busy;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rdata, bus_addr, bus_wdata;
    logic [NCH-1:0] gdma_stop;

    logic [7:0] mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];

    always #4 clk = ~clk;

    hdma_engine dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_strobe(line_strobe),
        .chan_en(chan_en), .cfg_src(cfg_src), .cfg_mode(cfg_mode), .cfg_indir(cfg_indir),
        .cfg_dest(cfg_dest), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .gdma_req(gdma_req),
        .gdma_grant(gdma_grant), .gdma_stop(gdma_stop), .busy(busy)
    );

    int n_chk = 0, n_fail = 0;
    int log_n = 0, busy_n = 0, stop_n = 0, clash_n = 0;
    logic [7:0] log_a [32];
    logic [7:0] log_d [32];
    logic [7:0] exp_a [16];
    logic [7:0] exp_d [16];

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_we && log_n < 32) begin
                log_a[log_n] = bus_addr;
                log_d[log_n] = bus_wdata;
                log_n++;
            end
            if (busy) busy_n++;
            if (|gdma_stop) stop_n++;
            if (busy && gdma_grant) clash_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_log(input string req, input int n);
        chk(log_n == n, {req, " write count"}, log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            chk(log_a[i] == exp_a[i], {req, " write addr"}, int'(log_a[i]), int'(exp_a[i]));
            chk(log_d[i] == exp_d[i], {req, " write data"}, int'(log_d[i]), int'(exp_d[i]));
        end
    endtask

    task automatic run_job(input bit ln, input bit fr, input int cycles);
        @(posedge clk); #1;
        log_n = 0; busy_n = 0; stop_n = 0; clash_n = 0;
        line_strobe = ln; frame_start = fr;
        @(posedge clk); #1;
        line_strobe = 1'b0; frame_start = 1'b0;
        repeat (cycles) @(posedge clk);
        #1;
    endtask

    task automatic set_ch(input int ch, input logic [15:0] src, input logic [2:0] mode,
                          input bit ind, input logic [7:0] dest);
        cfg_src[ch*AW +: AW] = src;
        cfg_mode[ch*3 +: 3]  = mode;
        cfg_indir[ch]        = ind;
        cfg_dest[ch*8 +: 8]  = dest;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !bus_we && !mem_rd && gdma_stop == '0, "R1 reset idle",
            {busy, bus_we, mem_rd}, 0);
    endtask

    task automatic t_empty();
        chan_en = '0; gdma_req = 1'b1;
        run_job(1'b1, 1'b1, 30);
        chk(busy_n == 0, "R3 empty mask busy", busy_n, 0);
        chk(log_n == 0, "R3 empty mask writes", log_n, 0);
        @(negedge clk);
        chk(gdma_grant == 1'b1, "R11 grant when idle", gdma_grant, 1);
        gdma_req = 1'b0;
        @(negedge clk);
        chk(gdma_grant == 1'b0, "R11 no grant without request", gdma_grant, 0);
    endtask

    task automatic t_direct();
        mem[8'h10] = 8'h02; mem[8'h11] = 8'hA1; mem[8'h12] = 8'hA2; mem[8'h13] = 8'h81;
        mem[8'h14] = 8'hB1; mem[8'h15] = 8'hB2; mem[8'h16] = 8'h00;
        set_ch(0, 16'h0010, 3'd1, 1'b0, 8'h18);
        chan_en = 8'h01;
        run_job(1'b0, 1'b1, 40);
        chk(log_n == 0, "R4 init moves no data", log_n, 0);
        chk(stop_n == 1, "R12 stop pulse per job", stop_n, 1);
        run_job(1'b1, 1'b0, 40);
        exp_a[0] = 8'h18; exp_d[0] = 8'hA1; exp_a[1] = 8'h19; exp_d[1] = 8'hA2;
        chk_log("R7 direct first line", 2);
        run_job(1'b1, 1'b0, 40);
        chk_log("R9 no repeat second line", 0);
        run_job(1'b1, 1'b0, 40);
        exp_a[0] = 8'h18; exp_d[0] = 8'hB1; exp_a[1] = 8'h19; exp_d[1] = 8'hB2;
        chk_log("R9 reload after count", 2);
        run_job(1'b1, 1'b0, 40);
        chk_log("R5 finished channel silent", 0);
        chk(busy_n == 9, "R10 idle job length", busy_n, 9);
    endtask

    task automatic t_indirect();
        mem[8'h40] = 8'h82; mem[8'h41] = 8'h80; mem[8'h42] = 8'h00; mem[8'h43] = 8'h00;
        mem[8'h80] = 8'h5C; mem[8'h81] = 8'h5D;
        set_ch(1, 16'h0040, 3'd0, 1'b1, 8'h22);
        chan_en = 8'h02;
        run_job(1'b0, 1'b1, 40);
        chk(log_n == 0, "R4 indirect init no data", log_n, 0);
        run_job(1'b1, 1'b0, 40);
        exp_a[0] = 8'h22; exp_d[0] = 8'h5C;
        chk_log("R8 indirect first byte", 1);
        run_job(1'b1, 1'b0, 40);
        exp_a[0] = 8'h22; exp_d[0] = 8'h5D;
        chk_log("R8 R9 indirect repeat advance", 1);
        run_job(1'b1, 1'b0, 40);
        chk_log("R5 indirect end", 0);
    endtask

    task automatic load_multi_exp();
        exp_a[0] = 8'h30; exp_d[0] = 8'h11; exp_a[1] = 8'h30; exp_d[1] = 8'h12;
        exp_a[2] = 8'h31; exp_d[2] = 8'h13; exp_a[3] = 8'h31; exp_d[3] = 8'h14;
        exp_a[4] = 8'h40; exp_d[4] = 8'h21; exp_a[5] = 8'h41; exp_d[5] = 8'h22;
        exp_a[6] = 8'h42; exp_d[6] = 8'h23; exp_a[7] = 8'h43; exp_d[7] = 8'h24;
    endtask

    task automatic t_multi();
        mem[8'h60] = 8'h01; mem[8'h61] = 8'h11; mem[8'h62] = 8'h12; mem[8'h63] = 8'h13;
        mem[8'h64] = 8'h14; mem[8'h65] = 8'h00;
        mem[8'h70] = 8'h01; mem[8'h71] = 8'h21; mem[8'h72] = 8'h22; mem[8'h73] = 8'h23;
        mem[8'h74] = 8'h24; mem[8'h75] = 8'h00;
        mem[8'h50] = 8'h00;
        set_ch(0, 16'h0060, 3'd3, 1'b0, 8'h30);
        set_ch(2, 16'h0070, 3'd4, 1'b0, 8'h40);
        set_ch(3, 16'h0050, 3'd0, 1'b0, 8'h50);
        chan_en = 8'b0000_1101;
        run_job(1'b0, 1'b1, 60);
        run_job(1'b1, 1'b0, 60);
        load_multi_exp();
        chk_log("R6 R13 modes 3 and 4 ascending", 8);
        run_job(1'b1, 1'b0, 60);
        chk_log("R5 zero count at init", 0);
        chk(busy_n == 9, "R10 all finished job length", busy_n, 9);
    endtask

    task automatic t_coincide();
        gdma_req = 1'b1;
        run_job(1'b1, 1'b1, 120);
        chk(stop_n == 2, "R12 two jobs queued", stop_n, 2);
        chk(clash_n == 0, "R11 grant held off while busy", clash_n, 0);
        chk(gdma_grant == 1'b1, "R11 grant returns", gdma_grant, 1);
        gdma_req = 1'b0;
        run_job(1'b1, 1'b0, 60);
        load_multi_exp();
        chk_log("R11 R2 line before init then replay", 8);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_empty();
        t_direct();
        t_indirect();
        t_multi();
        t_coincide();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule